// File: doc/BRIEF.md
# Second-Operand Shifter

This combinational block produces the second ALU operand and the shifter carry for a 32-bit load/store processor. The 12-bit operand field of a data-processing instruction comes in with an immediate-select bit, the values of the shifted register and of the shift-amount register, and the current carry flag. The block returns the operand value and the carry the shifter would hand to the flags logic. It has no state, so both outputs follow the inputs within the same cycle.

In immediate form, an 8-bit constant is zero-extended and rotated right by an even amount. In register form, the shifted-register value goes through one of four shift kinds. The shift amount is either a 5-bit constant from the field or the low byte of the amount register. Some amounts are special. Zero in the constant encodings stands for a shift of 32, or for a 33-bit rotate through the carry. A register amount of zero leaves the value alone, and register amounts of 32 and above saturate. The caller selects registers and reads the register file; this block only sees the values.

Top module: `op2_shifter`

## Requirements
- R1: With `imm_sel` high, `operand_out` is `op2_field[7:0]` zero-extended to 32 bits and rotated right by twice `op2_field[11:8]`.
- R2: With `imm_sel` high, `carry_out` equals `carry_in` when `op2_field[11:8]` is zero, and otherwise equals bit 31 of `operand_out`.
- R3: With `imm_sel` low, `op2_field[6:5]` picks the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. When `op2_field[4]` is 0 the amount is `op2_field[11:7]`; when it is 1 the amount is `rs_val[7:0]` and `op2_field[11:7]` has no effect.
- R4: Logical left fills with zeros and `carry_out` is the last bit shifted out. A constant amount of zero returns `rm_val` with `carry_in`.
- R5: Logical right fills with zeros and `carry_out` is the last bit shifted out. A constant amount of zero acts as a shift of 32: the result is 0 and the carry is `rm_val[31]`.
- R6: Arithmetic right fills with copies of `rm_val[31]` and `carry_out` is the last bit shifted out. A constant amount of zero gives all bits and the carry equal to `rm_val[31]`.
- R7: A constant rotate amount of 1 to 31 rotates `rm_val` right, with `carry_out` equal to result bit 31. A constant rotate amount of zero gives `{carry_in, rm_val[31:1]}` with `carry_out = rm_val[0]`.
- R8: A register amount of zero returns `rm_val` and `carry_in` for every shift kind.
- R9: A register amount of exactly 32 gives a result of 0, with carry `rm_val[0]` for logical left and `rm_val[31]` for logical right. A register amount above 32 gives 0 with carry 0 for both logical kinds.
- R10: A register amount of 32 or more for arithmetic right gives all bits equal to `rm_val[31]`, and the carry is also `rm_val[31]`.
- R11: A register rotate amount that is non-zero with its low five bits zero returns `rm_val` with carry `rm_val[31]`. Any other non-zero register rotate amount rotates by the low five bits, with carry equal to result bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op2_field | input | 12 | Operand field of the instruction |
| imm_sel | input | 1 | 1 selects the rotated constant, 0 the shifted register |
| rm_val | input | 32 | Value of the register being shifted |
| rs_val | input | 32 | Value of the register holding a shift amount |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The block keeps no state, so any fault shows at the ports in the same cycle as the inputs that trigger it. A wrong special-amount decode shows up only for the encodings that reach it. A constant of zero turned into a shift of 32 or into a rotate through the carry, a register amount of exactly 32, and register rotates by multiples of 32 are the cases where a slip changes the carry bit while the data word stays right, or the reverse. For that reason the bench aims both directed and random stimulus at those amounts and compares both outputs on every vector.

// File: rtl/op2_shift_pkg.sv
package op2_shift_pkg;

  localparam int AMT_W = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  // Normalised shift request: constant-amount special cases are folded
  // into an explicit amount or the rrx flag before the shift core sees them.
  typedef struct packed {
    shift_kind_e      kind;
    logic [AMT_W-1:0] amt;
    logic             rrx;
  } shift_req_t;

endpackage

// File: rtl/op2_imm_rotator.sv
module op2_imm_rotator #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_val,
  input  logic [ROT_W-1:0]  rot_field,
  input  logic              carry_in,
  output logic [DATA_W-1:0] rot_result,
  output logic              rot_carry
);
  localparam int RAMT_W = ROT_W + 1;

  logic [RAMT_W-1:0] rot_amt;
  logic              rot_nonzero;
  logic [DATA_W-1:0] imm_ext;

  function automatic logic [DATA_W-1:0] ror_word(input logic [DATA_W-1:0] v,
                                                 input logic [RAMT_W-1:0] n);
    if (n == '0) return v;
    return (v >> n) | (v << (DATA_W - int'(n)));
  endfunction

  assign rot_amt     = {rot_field, 1'b0};
  assign rot_nonzero = |rot_field;
  assign imm_ext     = {{(DATA_W-IMM_W){1'b0}}, imm_val};
  assign rot_result  = ror_word(imm_ext, rot_amt);
  assign rot_carry   = rot_nonzero ? rot_result[DATA_W-1] : carry_in;

  always_comb begin
    if (!$isunknown({imm_val, rot_field, carry_in})) begin
      // R1
      imm_ones_chk: assert ($countones(rot_result) == $countones(imm_val));
      // R2
      imm_carry_keep_chk: assert (rot_nonzero ||
                                  (rot_carry == carry_in && rot_result[IMM_W-1:0] == imm_val));
    end
  end
endmodule

// File: rtl/op2_amount_decode.sv
module op2_amount_decode
  import op2_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12
) (
  input  logic [FIELD_W-1:0] op2_field,
  input  logic [AMT_W-1:0]   rs_amt,
  output shift_req_t         req
);
  localparam int SH_W       = $clog2(DATA_W);
  localparam int KIND_LSB   = 5;
  localparam int REGSEL_BIT = 4;
  localparam int IMMAMT_LSB = 7;

  logic [SH_W-1:0] imm_amt;
  logic            use_reg;
  shift_kind_e     kind;
  wire  [3:0]      field_low_unused = op2_field[3:0];

  assign imm_amt = op2_field[IMMAMT_LSB +: SH_W];
  assign use_reg = op2_field[REGSEL_BIT];
  assign kind    = shift_kind_e'(op2_field[KIND_LSB +: 2]);

  always_comb begin
    req.kind = kind;
    req.rrx  = 1'b0;
    req.amt  = AMT_W'(imm_amt);
    if (use_reg) begin
      req.amt = rs_amt;
    end else if (imm_amt == '0) begin
      unique case (kind)
        SH_LSL: req.amt = '0;
        SH_LSR,
        SH_ASR: req.amt = AMT_W'(DATA_W);
        SH_ROR: begin
          req.amt = '0;
          req.rrx = 1'b1;
        end
        default: req.amt = '0;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({op2_field, rs_amt})) begin
      // R3
      imm_amt_range_chk: assert (use_reg || req.amt <= AMT_W'(DATA_W));
      // R7
      rrx_only_ror_chk: assert (!req.rrx || (req.kind == SH_ROR && req.amt == '0 && !use_reg));
    end
  end
endmodule

// File: rtl/op2_shift_core.sv
module op2_shift_core
  import op2_shift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  shift_req_t        req,
  input  logic [DATA_W-1:0] src,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sh_result,
  output logic              sh_carry
);
  localparam int SH_W = $clog2(DATA_W);
  localparam int MSB  = DATA_W - 1;

  logic              pass_through;
  logic [DATA_W:0]   res_w;

  // {carry, result}
  function automatic logic [DATA_W:0] lsl_op(input logic [DATA_W-1:0] v,
                                             input logic [AMT_W-1:0] n);
    logic [DATA_W:0] t;
    t = {1'b0, v} << n;
    return t;
  endfunction

  function automatic logic [DATA_W:0] lsr_op(input logic [DATA_W-1:0] v,
                                             input logic [AMT_W-1:0] n);
    logic [DATA_W:0] t;
    t = {v, 1'b0} >> n;
    return {t[0], t[DATA_W:1]};
  endfunction

  function automatic logic [DATA_W:0] asr_op(input logic [DATA_W-1:0] v,
                                             input logic [AMT_W-1:0] n);
    logic [DATA_W:0] t;
    t = $signed({v, 1'b0}) >>> n;
    return {t[0], t[DATA_W:1]};
  endfunction

  function automatic logic [DATA_W:0] ror_op(input logic [DATA_W-1:0] v,
                                             input logic [AMT_W-1:0] n);
    logic [SH_W-1:0]   a;
    logic [DATA_W-1:0] r;
    a = n[SH_W-1:0];
    if (a == '0) return {v[DATA_W-1], v};
    r = (v >> a) | (v << (DATA_W - int'(a)));
    return {r[DATA_W-1], r};
  endfunction

  function automatic logic [DATA_W:0] rrx_op(input logic [DATA_W-1:0] v,
                                             input logic c);
    return {v[0], c, v[DATA_W-1:1]};
  endfunction

  assign pass_through = !req.rrx && (req.amt == '0);

  always_comb begin
    if (req.rrx) begin
      res_w = rrx_op(src, carry_in);
    end else if (pass_through) begin
      res_w = {carry_in, src};
    end else begin
      unique case (req.kind)
        SH_LSL:  res_w = lsl_op(src, req.amt);
        SH_LSR:  res_w = lsr_op(src, req.amt);
        SH_ASR:  res_w = asr_op(src, req.amt);
        SH_ROR:  res_w = ror_op(src, req.amt);
        default: res_w = {carry_in, src};
      endcase
    end
  end

  assign sh_result = res_w[DATA_W-1:0];
  assign sh_carry  = res_w[DATA_W];

  always_comb begin
    if (!$isunknown({req, src, carry_in})) begin
      // R8
      pass_keep_chk: assert (!pass_through || (sh_result == src && sh_carry == carry_in));
      // R4
      lsl_zero_fill_chk: assert (!(req.kind == SH_LSL && !pass_through) || !sh_result[0]);
      // R5
      lsr_zero_fill_chk: assert (!(req.kind == SH_LSR && !pass_through) || !sh_result[MSB]);
      // R6
      asr_sign_fill_chk: assert (req.kind != SH_ASR || sh_result[MSB] == src[MSB]);
      // R7
      rrx_carry_chk: assert (!req.rrx || (sh_result[MSB] == carry_in && sh_carry == src[0]));
      // R11
      ror_ones_chk: assert (req.kind != SH_ROR || req.rrx ||
                            $countones(sh_result) == $countones(src));
    end
  end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
  import op2_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 12,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4
) (
  input  logic [FIELD_W-1:0] op2_field,
  input  logic               imm_sel,
  input  logic [DATA_W-1:0]  rm_val,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  operand_out,
  output logic               carry_out
);
  logic [DATA_W-1:0] imm_result;
  logic              imm_carry;
  logic [DATA_W-1:0] reg_result;
  logic              reg_carry;
  shift_req_t        shift_req;
  wire               rs_high_unused = ^rs_val[DATA_W-1:AMT_W];

  op2_imm_rotator #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm_val    (op2_field[IMM_W-1:0]),
    .rot_field  (op2_field[IMM_W +: ROT_W]),
    .carry_in   (carry_in),
    .rot_result (imm_result),
    .rot_carry  (imm_carry)
  );

  op2_amount_decode #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_dec (
    .op2_field (op2_field),
    .rs_amt    (rs_val[AMT_W-1:0]),
    .req       (shift_req)
  );

  op2_shift_core #(.DATA_W(DATA_W)) u_core (
    .req       (shift_req),
    .src       (rm_val),
    .carry_in  (carry_in),
    .sh_result (reg_result),
    .sh_carry  (reg_carry)
  );

  assign operand_out = imm_sel ? imm_result : reg_result;
  assign carry_out   = imm_sel ? imm_carry  : reg_carry;

  always_comb begin
    if (!$isunknown({op2_field, imm_sel, rm_val, rs_val, carry_in})) begin
      // R9
      big_logical_zero_chk: assert (!(!imm_sel && op2_field[4] && !op2_field[6] &&
                                      rs_val[AMT_W-1:0] > AMT_W'(DATA_W)) ||
                                    (operand_out == '0 && !carry_out));
      // R10
      big_asr_sign_chk: assert (!(!imm_sel && op2_field[4] && op2_field[6:5] == 2'b10 &&
                                  rs_val[AMT_W-1:0] >= AMT_W'(DATA_W)) ||
                                (operand_out == {DATA_W{rm_val[DATA_W-1]}} &&
                                 carry_out == rm_val[DATA_W-1]));
    end
  end
endmodule

// File: tb/op2_shifter_test.sv
`timescale 1ns/1ps
module op2_shifter_test;
  logic        clk = 1'b0;
  logic [11:0] op2_field = '0;
  logic        imm_sel = 1'b0;
  logic [31:0] rm_val = '0;
  logic [31:0] rs_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] operand_out;
  logic        carry_out;
  int          n_checks = 0;
  int          n_fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  op2_shifter uut (
    .op2_field(op2_field), .imm_sel(imm_sel), .rm_val(rm_val),
    .rs_val(rs_val), .carry_in(carry_in),
    .operand_out(operand_out), .carry_out(carry_out)
  );

  // Bit-serial reference: one step per position moved.
  function automatic logic [32:0] ref_op2(input logic [11:0] f, input logic im,
                                          input logic [31:0] rm, input logic [31:0] rs,
                                          input logic c);
    logic [31:0] v;
    logic        cy;
    int          n;
    int          k;
    cy = c;
    if (im) begin
      v = {24'b0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
      if (n != 0) cy = v[31];
      return {cy, v};
    end
    v = rm;
    k = int'(f[6:5]);
    if (f[4]) n = int'(rs[7:0]);
    else begin
      n = int'(f[11:7]);
      if (n == 0) begin
        if (k == 1 || k == 2) n = 32;
        else if (k == 3) return {rm[0], c, rm[31:1]};
      end
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        0: begin cy = v[31]; v = {v[30:0], 1'b0}; end
        1: begin cy = v[0];  v = {1'b0, v[31:1]}; end
        2: begin cy = v[0];  v = {v[31], v[31:1]}; end
        default: begin cy = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {cy, v};
  endfunction

  function automatic string tag_of(input logic [11:0] f, input logic im, input logic [31:0] rs);
    if (im) return "R1";
    if (f[4]) begin
      if (rs[7:0] == 8'd0) return "R8";
      if (rs[7:0] >= 8'd32) begin
        case (f[6:5])
          2'b00, 2'b01: return "R9";
          2'b10: return "R10";
          default: return "R11";
        endcase
      end
      if (f[6:5] == 2'b11) return "R11";
    end
    case (f[6:5])
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run(input string req, input logic [11:0] f, input logic im,
                     input logic [31:0] rm, input logic [31:0] rs, input logic c);
    logic [32:0] exp;
    @(negedge clk);
    op2_field = f; imm_sel = im; rm_val = rm; rs_val = rs; carry_in = c;
    exp = ref_op2(f, im, rm, rs, c);
    @(posedge clk);
    #1;
    n_checks++;
    if (operand_out !== exp[31:0] || carry_out !== exp[32]) begin
      n_fails++;
      $display("FAIL %s field=%h imm=%b rm=%h rs=%h cin=%b: got %h/%b expected %h/%b",
               req, f, im, rm, rs, c, operand_out, carry_out, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    // all-zero inputs: operand 0, carry 0 (R8 style pass-through of zero)
    run("R4", 12'h000, 1'b0, 32'h0, 32'h0, 1'b0);
    // R1 / R2 directed
    run("R1", 12'h4FF, 1'b1, 32'h0, 32'h0, 1'b0);
    run("R2", 12'h0A5, 1'b1, 32'h0, 32'h0, 1'b1);
    run("R2", 12'h1C3, 1'b1, 32'h0, 32'h0, 1'b0);
    run("R1", 12'hF81, 1'b1, 32'h0, 32'h0, 1'b0);
    // R4 constant amounts
    run("R4", 12'h000, 1'b0, 32'hDEADBEEF, 32'h0, 1'b1);
    run("R4", 12'h080, 1'b0, 32'h80000001, 32'h0, 1'b0);
    run("R4", 12'hF80, 1'b0, 32'h00000003, 32'h0, 1'b0);
    // R5 / R6 constant zero means 32
    run("R5", 12'h020, 1'b0, 32'h80000000, 32'h0, 1'b0);
    run("R5", 12'h0A0, 1'b0, 32'h00000001, 32'h0, 1'b0);
    run("R6", 12'h040, 1'b0, 32'h80000000, 32'h0, 1'b0);
    run("R6", 12'h040, 1'b0, 32'h7FFFFFFF, 32'h0, 1'b1);
    run("R6", 12'h240, 1'b0, 32'hF0000010, 32'h0, 1'b0);
    // R7 rotate and rotate through carry
    run("R7", 12'h060, 1'b0, 32'h00000001, 32'h0, 1'b1);
    run("R7", 12'h060, 1'b0, 32'h00000002, 32'h0, 1'b0);
    run("R7", 12'h260, 1'b0, 32'h00000010, 32'h0, 1'b0);
    // R3 amount from register ignores bits 11:7
    run("R3", 12'hF90, 1'b0, 32'h12345678, 32'hFFFFFF04, 1'b0);
    // R8 register amount zero, each kind
    for (int k = 0; k < 4; k++)
      run("R8", 12'h010 | 12'(k << 5), 1'b0, 32'hA5A5F00F, 32'hFFFFFF00, 1'b1);
    // R9 register amount 32 and above
    run("R9", 12'h010, 1'b0, 32'h00000001, 32'd32, 1'b0);
    run("R9", 12'h030, 1'b0, 32'h80000000, 32'd32, 1'b0);
    run("R9", 12'h010, 1'b0, 32'hFFFFFFFF, 32'd33, 1'b1);
    run("R9", 12'h030, 1'b0, 32'hFFFFFFFF, 32'd200, 1'b1);
    // R10
    run("R10", 12'h050, 1'b0, 32'h80000000, 32'd32, 1'b0);
    run("R10", 12'h050, 1'b0, 32'h7FFFFFFF, 32'd255, 1'b1);
    // R11
    run("R11", 12'h070, 1'b0, 32'h80000001, 32'd32, 1'b0);
    run("R11", 12'h070, 1'b0, 32'h00000001, 32'd64, 1'b0);
    run("R11", 12'h070, 1'b0, 32'h00000003, 32'd33, 1'b0);
    run("R11", 12'h070, 1'b0, 32'h00000100, 32'd8, 1'b1);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] f;
      logic        im;
      logic [31:0] rm;
      logic [31:0] rs;
      logic        c;
      f  = 12'($urandom);
      im = 1'($urandom);
      rm = $urandom;
      rs = $urandom;
      c  = 1'($urandom);
      case ($urandom % 6)
        0: rs[7:0] = 8'd0;
        1: rs[7:0] = 8'd32;
        2: rs[7:0] = 8'($urandom % 40);
        3: f[11:7] = 5'd0;
        default: ;
      endcase
      if (!im && f[4]) f[7] = 1'b0;
      run(tag_of(f, im, rs), f, im, rm, rs, c);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule